// File: doc/BRIEF.md
# Reset Cause Status Register

This block is the 32-bit status word of a reset sequencer that has several reset sources. It holds sticky flags that record what started a reset. There is one flag for each of up to ten external reset inputs, one for a software reset request and one for the power-on cause. It also holds sticky flags for the rising edges of ten deassertion qualification inputs and for the two points where the sequencer waits for software approval. One live bit mirrors whether a reset sequence is running.

Software reads the word on `rd_data`, which is always valid. It clears individual flags by writing ones to their positions. Zero bits in a write leave the matching flags unchanged.

The register's own reset clears every sticky flag except the power-on cause, which that reset sets. As a result, the power-on cause is still visible after the sequencer itself has come out of reset. The block has no state machine. Its state is a bank of independent sticky flags and one edge-detect register for each qualification input.

Top module: `rcs_status_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released with no events pending and `seq_active` low, `rd_data` reads 32'h0000_0001: bit 0 is set and every other bit is 0.
- R2: A one-cycle high on `src_trig[n]` sets bit n+2 of `rd_data` after the next clock edge. The bit stays set until it is cleared.
- R3: A one-cycle high on `sw_trig` sets bit 1 after the next clock edge. The bit stays set until it is cleared.
- R4: Bit 16+n is set by a rising edge of `qual_in[n]`, seen against a registered copy of that input. If the input is held high after the bit has been cleared, the bit is not set again.
- R5: `wait_assert` high at a clock edge sets bit 30, and `wait_deassert` high sets bit 29. Both bits are sticky. An instance built with `SW_ASSERT_EN` = 0 keeps bit 30 at 0, and one built with `SW_DEASSERT_EN` = 0 keeps bit 29 at 0.
- R6: Bit 31 equals `seq_active` in the same cycle and cannot be written.
- R7: A write (`wr_en` high at a clock edge) clears every sticky bit whose `wr_data` bit is 1, from the next cycle on. Bits written with 0 are unchanged.
- R8: When a set event and a write-one-to-clear reach the same bit at the same edge, the bit ends up set.
- R9: Bits 28:26 and 15:12 always read 0, whatever is written.
- R10: Bit 0 has no set source other than `rst_n`. Once it has been cleared by a write, it stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register; also sets the power-on cause bit |
| src_trig | input | NUM_SRC | Trigger pulses from the external reset inputs |
| sw_trig | input | 1 | Software reset trigger pulse |
| qual_in | input | NUM_QUAL | Deassertion qualification inputs; a flag is set on each rising edge |
| seq_active | input | 1 | Sequencer is running an assertion or deassertion sequence |
| wait_assert | input | 1 | Assertion step is waiting for software approval |
| wait_deassert | input | 1 | Deassertion step is waiting for software approval |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data; each 1 clears the sticky bit at that position |
| rd_data | output | 32 | Current status word |

## Verification
Every sticky result (R2, R3, R4, R5, R7, R8) changes at the first clock edge after its stimulus is applied. The edge detect in R4 compares against the previous cycle's copy, so it adds no extra cycle. Bit 31 (R6) is combinational and is due in the same cycle. The bench changes inputs on falling edges and samples one falling edge later, so exactly one rising edge lies between a stimulus and its check. Bit 31 is checked a short delay after the input changes. Checks that something is ignored are made one cycle later, with a further idle cycle where it matters.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned POR_BIT   = 0;
    localparam int unsigned SWR_BIT   = 1;
    localparam int unsigned SRC_LSB   = 2;
    localparam int unsigned QUAL_LSB  = 16;
    localparam int unsigned WDSRT_BIT = 29;
    localparam int unsigned WASRT_BIT = 30;
    localparam int unsigned ACT_BIT   = 31;
    localparam int unsigned MAX_SRC   = 10;
    localparam int unsigned MAX_QUAL  = 10;
endpackage

// File: rtl/rcs_rise_det.sv
module rcs_rise_det #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/rcs_sticky_bank.sv
module rcs_sticky_bank #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag_q;

    // set has priority over clear so that an event is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
    import rcs_pkg::*;
#(
    parameter int unsigned NUM_SRC        = 10,
    parameter int unsigned NUM_QUAL       = 10,
    parameter bit          SW_ASSERT_EN   = 1'b1,
    parameter bit          SW_DEASSERT_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_trig,
    input  logic                sw_trig,
    input  logic [NUM_QUAL-1:0] qual_in,
    input  logic                seq_active,
    input  logic                wait_assert,
    input  logic                wait_deassert,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int unsigned CAUSE_W = NUM_SRC + 2;
    localparam logic [CAUSE_W-1:0] CAUSE_RST = CAUSE_W'(1);
    localparam logic [WORD_W-1:0] USED_MASK =
        ({{(WORD_W-CAUSE_W){1'b0}}, {CAUSE_W{1'b1}}}) |
        ({{(WORD_W-NUM_QUAL){1'b0}}, {NUM_QUAL{1'b1}}} << QUAL_LSB) |
        (WORD_W'(SW_DEASSERT_EN) << WDSRT_BIT) |
        (WORD_W'(SW_ASSERT_EN) << WASRT_BIT);

    initial begin
        if (NUM_SRC > MAX_SRC || NUM_QUAL > MAX_QUAL || NUM_SRC == 0 || NUM_QUAL == 0)
            $error("rcs_status_reg: source or qualifier count out of range");
    end

    logic [WORD_W-1:0]   clr_vec;
    logic [CAUSE_W-1:0]  cause_q;
    logic [NUM_QUAL-1:0] qual_rise;
    logic [NUM_QUAL-1:0] qual_q;
    logic                wasrt_q;
    logic                wdsrt_q;
    logic                unused_wr;

    assign clr_vec   = wr_en ? wr_data : '0;
    assign unused_wr = ^(clr_vec & ~USED_MASK);

    // cause flags: bit 0 power-on (no set source), bit 1 software, then sources
    rcs_sticky_bank #(.W(CAUSE_W), .RST_VAL(CAUSE_RST)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({src_trig, sw_trig, 1'b0}),
        .clr_i (clr_vec[CAUSE_W-1:0]),
        .q_o   (cause_q)
    );

    rcs_rise_det #(.W(NUM_QUAL)) u_qual_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (qual_in),
        .rise_o (qual_rise)
    );

    rcs_sticky_bank #(.W(NUM_QUAL)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (qual_rise),
        .clr_i (clr_vec[QUAL_LSB +: NUM_QUAL]),
        .q_o   (qual_q)
    );

    generate
        if (SW_ASSERT_EN) begin : g_wasrt
            rcs_sticky_bank #(.W(1)) u_wasrt (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (wait_assert),
                .clr_i (clr_vec[WASRT_BIT]),
                .q_o   (wasrt_q)
            );
        end else begin : g_no_wasrt
            assign wasrt_q = 1'b0;
        end

        if (SW_DEASSERT_EN) begin : g_wdsrt
            rcs_sticky_bank #(.W(1)) u_wdsrt (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (wait_deassert),
                .clr_i (clr_vec[WDSRT_BIT]),
                .q_o   (wdsrt_q)
            );
        end else begin : g_no_wdsrt
            assign wdsrt_q = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_data                        = '0;
        rd_data[CAUSE_W-1:0]           = cause_q;
        rd_data[QUAL_LSB +: NUM_QUAL]  = qual_q;
        rd_data[WDSRT_BIT]             = wdsrt_q;
        rd_data[WASRT_BIT]             = wasrt_q;
        rd_data[ACT_BIT]               = seq_active;
    end
endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk
    import rcs_pkg::*;
#(
    parameter int unsigned NUM_SRC        = 10,
    parameter int unsigned NUM_QUAL       = 10,
    parameter bit          SW_ASSERT_EN   = 1'b1,
    parameter bit          SW_DEASSERT_EN = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  src_trig,
    input logic                sw_trig,
    input logic [NUM_QUAL-1:0] qual_in,
    input logic                seq_active,
    input logic                wait_assert,
    input logic                wait_deassert,
    input logic                wr_en,
    input logic [WORD_W-1:0]   wr_data,
    input logic [WORD_W-1:0]   rd_data
);
    // R2
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_trig) |=> ((rd_data[SRC_LSB +: NUM_SRC] & $past(src_trig)) == $past(src_trig)));

    // R3
    sw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> rd_data[SWR_BIT]);

    // R6
    active_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[ACT_BIT] == seq_active);

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|src_trig) && !sw_trig) |=>
            ((rd_data[SRC_LSB+NUM_SRC-1:0] & $past(wr_data[SRC_LSB+NUM_SRC-1:0])) == '0));

    // R7
    hold_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[25:0] & $past(rd_data[25:0])) == $past(rd_data[25:0])));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sw_trig && wr_data[SWR_BIT]) |=> rd_data[SWR_BIT]);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[28:26] == 3'b000) && (rd_data[15:12] == 4'b0000));

    // R10
    por_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[POR_BIT] |=> !rd_data[POR_BIT]);

    generate
        if (SW_ASSERT_EN) begin : g_wa
            // R5
            wait_assert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wait_assert |=> rd_data[WASRT_BIT]);
        end else begin : g_nwa
            // R5
            wait_assert_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[WASRT_BIT]);
        end
        if (SW_DEASSERT_EN) begin : g_wd
            // R5
            wait_deassert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wait_deassert |=> rd_data[WDSRT_BIT]);
        end else begin : g_nwd
            // R5
            wait_deassert_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[WDSRT_BIT]);
        end
    endgenerate
endmodule

bind rcs_status_reg rcs_status_chk #(
    .NUM_SRC        (NUM_SRC),
    .NUM_QUAL       (NUM_QUAL),
    .SW_ASSERT_EN   (SW_ASSERT_EN),
    .SW_DEASSERT_EN (SW_DEASSERT_EN)
) u_chk (.*);

// File: tb/rcs_status_reg_tb.sv
module rcs_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_trig = '0;
    logic        sw_trig = 1'b0;
    logic [9:0]  qual_in = '0;
    logic        seq_active = 1'b0;
    logic        wait_assert = 1'b0;
    logic        wait_deassert = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] rd_plain;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_v;

    always #5 clk = ~clk;

    rcs_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .src_trig(src_trig), .sw_trig(sw_trig),
        .qual_in(qual_in), .seq_active(seq_active), .wait_assert(wait_assert),
        .wait_deassert(wait_deassert), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    rcs_status_reg #(.SW_ASSERT_EN(1'b0), .SW_DEASSERT_EN(1'b0)) u_dut_plain (
        .clk(clk), .rst_n(rst_n), .src_trig(src_trig), .sw_trig(sw_trig),
        .qual_in(qual_in), .seq_active(seq_active), .wait_assert(wait_assert),
        .wait_deassert(wait_deassert), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_plain)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        chk("R1 during reset", rd_data, 32'h1);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 after release", rd_data, 32'h1);
        chk("R1 plain after release", rd_plain, 32'h1);
        exp_v = 32'h1;
    endtask

    task automatic t_sources();
        for (int n = 0; n < 10; n++) begin
            src_trig[n] = 1'b1;
            tick();
            src_trig[n] = 1'b0;
            exp_v[n+2] = 1'b1;
            chk($sformatf("R2 source %0d", n), rd_data, exp_v);
        end
        tick();
        chk("R2 sticky after idle", rd_data, exp_v);
        write_word(32'h0000_0FFC);
        exp_v = 32'h1;
        chk("R7 clear sources", rd_data, exp_v);
    endtask

    task automatic t_software();
        sw_trig = 1'b1;
        tick();
        sw_trig = 1'b0;
        exp_v[1] = 1'b1;
        chk("R3 software cause", rd_data, exp_v);
        tick();
        chk("R3 sticky", rd_data, exp_v);
    endtask

    task automatic t_write_zero();
        src_trig[5] = 1'b1;
        tick();
        src_trig[5] = 1'b0;
        exp_v[7] = 1'b1;
        write_word(32'h0);
        chk("R7 zero write keeps bits", rd_data, exp_v);
        write_word(32'h0000_0080);
        exp_v[7] = 1'b0;
        chk("R7 single bit clear", rd_data, exp_v);
    endtask

    task automatic t_qual();
        qual_in[3] = 1'b1;
        tick();
        exp_v[19] = 1'b1;
        chk("R4 rising edge sets", rd_data, exp_v);
        write_word(32'h0008_0000);
        exp_v[19] = 1'b0;
        chk("R4 cleared while high", rd_data, exp_v);
        tick();
        chk("R4 held level does not reset", rd_data, exp_v);
        qual_in[3] = 1'b0;
        tick();
        qual_in[9] = 1'b1;
        qual_in[0] = 1'b1;
        tick();
        exp_v[25] = 1'b1;
        exp_v[16] = 1'b1;
        chk("R4 two inputs", rd_data, exp_v);
        qual_in = '0;
        write_word(32'h0201_0000);
        exp_v[25] = 1'b0;
        exp_v[16] = 1'b0;
        chk("R7 clear qual", rd_data, exp_v);
    endtask

    task automatic t_wait();
        wait_assert = 1'b1;
        tick();
        wait_assert = 1'b0;
        exp_v[30] = 1'b1;
        chk("R5 wait assert", rd_data, exp_v);
        chk("R5 plain wait assert off", rd_plain[30], 1'b0);
        wait_deassert = 1'b1;
        tick();
        wait_deassert = 1'b0;
        exp_v[29] = 1'b1;
        chk("R5 wait deassert", rd_data, exp_v);
        chk("R5 plain wait deassert off", rd_plain[29], 1'b0);
        write_word(32'h6000_0000);
        exp_v[30] = 1'b0;
        exp_v[29] = 1'b0;
        chk("R7 clear wait bits", rd_data, exp_v);
    endtask

    task automatic t_active();
        seq_active = 1'b1;
        #1;
        chk("R6 active follows", rd_data[31], 1'b1);
        tick();
        write_word(32'h8000_0000);
        chk("R6 write ignored", rd_data[31], 1'b1);
        seq_active = 1'b0;
        #1;
        chk("R6 active drops", rd_data[31], 1'b0);
        tick();
    endtask

    task automatic t_collision();
        src_trig[4] = 1'b1;
        sw_trig = 1'b1;
        write_word(32'h0000_0042);
        src_trig[4] = 1'b0;
        sw_trig = 1'b0;
        exp_v[6] = 1'b1;
        exp_v[1] = 1'b1;
        chk("R8 set wins", rd_data, exp_v);
    endtask

    task automatic t_reserved_por();
        write_word(32'hFFFF_FFFF);
        exp_v = 32'h0;
        chk("R9 reserved after all-ones write", rd_data & 32'h1C00_F000, 32'h0);
        chk("R10 por cleared by write", rd_data, exp_v);
        tick();
        tick();
        chk("R10 por stays cleared", rd_data, exp_v);
    endtask

    task automatic t_reset_again();
        src_trig[0] = 1'b1;
        qual_in[1] = 1'b1;
        tick();
        src_trig[0] = 1'b0;
        qual_in[1] = 1'b0;
        chk("R2 before reset", rd_data, 32'h0002_0004);
        do_reset();
        chk("R10 reset sets por", rd_data[0], 1'b1);
    endtask

    initial begin
        tick();
        do_reset();
        t_sources();
        t_software();
        t_write_zero();
        t_qual();
        t_wait();
        t_active();
        t_collision();
        t_reserved_por();
        t_reset_again();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule